// File: doc/BRIEF.md
# Multi-channel I/Q output port formatter

This block gathers baseband samples from six gain-control channels and puts them out, one word at a time, on a single 16-bit output port. Each channel presents an I/Q pair with a one-cycle valid strobe. Separately, it presents a signal-strength (RSSI) value with its own update strobe. The block holds the newest pending sample of each channel and serves the channels in a fixed order. It emits every sample as one or more tagged words.

A configuration word is registered on every clock. It selects:
- which channels may use the port;
- the word format: one combined word carrying the upper halves of I and Q, or two full-width words (I, then Q);
- whether an RSSI word follows every sample, or only the first sample after each fresh RSSI update.

The port advances on a port tick. In master mode the tick is an internal division of the main clock by 1, 2, 4 or 8, and the block drives the port clock. In slave mode each rising edge of an external port clock produces one tick, and the divisor is ignored.

Top module: `iq_port_formatter`

## Requirements
- R1: A channel whose enable bit (bit c of `cfg_ch_en_i` for channel c) is clear captures no samples, and none of its data reaches the port.
- R2: At a port tick with no word sequence in progress, the enabled channel with a pending sample and the lowest index is served.
- R3: With `cfg_par_fmt_i`=1, a sample is emitted as one word with tag 2'b10, data = {I[15:8], Q[15:8]}.
- R4: With `cfg_par_fmt_i`=0, a sample is emitted as an I word (tag 2'b00, full I), then a Q word (tag 2'b01, full Q) on the next port tick.
- R5: With `cfg_rssi_all_i`=1, every sample is followed on the next port tick by an RSSI word (tag 2'b11) holding that channel's latest RSSI value.
- R6: With `cfg_rssi_all_i`=0, an RSSI word follows a channel's sample only if an RSSI update arrived since that channel was last served. Later samples carry none until the next update.
- R7: In master mode `port_ce_o` pulses once every 1, 2, 4 or 8 main-clock cycles, for `cfg_div_i` = 00, 01, 10 or 11, and `pclk_oe_o` is high.
- R8: In slave mode `pclk_oe_o` is low. `port_ce_o` pulses for exactly one cycle, in the cycle after each rising edge of `ext_pclk_i` is registered, whatever `cfg_div_i` holds.
- R9: After reset the port is in slave mode (`pclk_oe_o`=0), `out_vld_o`=0 and all overflow flags are 0.
- R10: Output data, tag and valid change only on the clock edge that ends a cycle with `port_ce_o` high, so each word is held for exactly one port clock.
- R11: A sample arriving while the same channel still has an unserved sample replaces it, and that channel's sticky `ovf_o` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ch_en_i | input | 6 | Per-channel port enable |
| cfg_par_fmt_i | input | 1 | 1: combined 8+8 I/Q word, 0: separate 16-bit I and Q words |
| cfg_rssi_all_i | input | 1 | 1: RSSI after every sample, 0: only after an update |
| cfg_master_i | input | 1 | 1: internal divided port clock, 0: external port clock |
| cfg_div_i | input | 2 | Master divisor select (1, 2, 4, 8) |
| ext_pclk_i | input | 1 | External port clock (slave mode) |
| smp_vld_i | input | 6 | Per-channel sample strobe |
| smp_i_i | input | 96 | I data, channel c in bits [16c+15:16c] |
| smp_q_i | input | 96 | Q data, channel c in bits [16c+15:16c] |
| rssi_upd_i | input | 6 | Per-channel RSSI update strobe |
| rssi_i | input | 96 | RSSI data, channel c in bits [16c+15:16c] |
| pclk_oe_o | output | 1 | Port clock drive enable (master mode) |
| port_ce_o | output | 1 | Port tick, one main-clock cycle wide |
| out_data_o | output | 16 | Output word |
| out_tag_o | output | 2 | Word type: 00 I, 01 Q, 10 combined I/Q, 11 RSSI |
| out_vld_o | output | 1 | Output word valid |
| ovf_o | output | 6 | Sticky per-channel overflow flags |

## Verification
Configuration is registered first, so it applies from the cycle after it is driven. A sample strobe sets the channel pending at the edge where it is seen. The sample can then be granted at the first later edge on which `port_ce_o` is high, and the resulting word appears just after that edge. In master mode `port_ce_o` follows from the divider count. In slave mode it rises one cycle after `ext_pclk_i` goes high.

The bench's behavioural model applies the same per-edge order: tick, then grant, then capture, then the configuration update. It compares tick, output word, tag, valid, drive enable and overflow flags 2 ns after every rising edge. Every registered output has settled by then, and no input has moved yet.

// File: rtl/iq_fmt_pkg.sv
package iq_fmt_pkg;
  typedef enum logic [1:0] {
    TAG_I    = 2'b00,
    TAG_Q    = 2'b01,
    TAG_IQ   = 2'b10,
    TAG_RSSI = 2'b11
  } tag_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_Q    = 2'b01,
    PH_RSSI = 2'b10
  } ph_e;
endpackage

// File: rtl/iq_port_tick.sv
module iq_port_tick #(
  parameter int CNT_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       master_i,
  input  logic [1:0] div_i,
  input  logic       ext_pclk_i,
  output logic       tick_o
);
  logic [CNT_W-1:0] cnt_q, div_max;
  logic             ext_d_q, ext_d2_q;

  assign div_max = (CNT_W'(1) << div_i) - CNT_W'(1);
  assign tick_o  = master_i ? (cnt_q == div_max) : (ext_d_q & ~ext_d2_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      ext_d_q  <= 1'b0;
      ext_d2_q <= 1'b0;
    end else begin
      cnt_q    <= (!master_i || tick_o) ? '0 : cnt_q + CNT_W'(1);
      ext_d_q  <= ext_pclk_i;
      ext_d2_q <= ext_d_q;
    end
  end

  // an external edge yields a single-cycle tick
  assert_slave_one_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && tick_o) |=> (!tick_o || master_i));
endmodule

// File: rtl/iq_chan_store.sv
module iq_chan_store #(
  parameter int N_CH  = 6,
  parameter int SMP_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_CH-1:0]         en_i,
  input  logic [N_CH-1:0]         smp_vld_i,
  input  logic [N_CH*SMP_W-1:0]   smp_i_i,
  input  logic [N_CH*SMP_W-1:0]   smp_q_i,
  input  logic [N_CH-1:0]         rssi_upd_i,
  input  logic [N_CH*SMP_W-1:0]   rssi_i,
  input  logic [N_CH-1:0]         take_i,
  output logic [N_CH-1:0]         pend_o,
  output logic [SMP_W-1:0]        pi_o [N_CH],
  output logic [SMP_W-1:0]        pq_o [N_CH],
  output logic [N_CH-1:0]         rpend_o,
  output logic [SMP_W-1:0]        rval_o [N_CH],
  output logic [N_CH-1:0]         ovf_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic cap;
    assign cap = en_i[c] & smp_vld_i[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[c]  <= 1'b0;
        rpend_o[c] <= 1'b0;
        ovf_o[c]   <= 1'b0;
        pi_o[c]    <= '0;
        pq_o[c]    <= '0;
        rval_o[c]  <= '0;
      end else begin
        pend_o[c]  <= cap | (pend_o[c] & ~take_i[c]);
        rpend_o[c] <= rssi_upd_i[c] | (rpend_o[c] & ~take_i[c]);
        if (cap) begin
          pi_o[c]  <= smp_i_i[c*SMP_W +: SMP_W];
          pq_o[c]  <= smp_q_i[c*SMP_W +: SMP_W];
          ovf_o[c] <= ovf_o[c] | (pend_o[c] & ~take_i[c]);
        end
        if (rssi_upd_i[c]) rval_o[c] <= rssi_i[c*SMP_W +: SMP_W];
      end
    end

    assert_ovf_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o[c] |=> ovf_o[c]);
  end
endmodule

// File: rtl/iq_word_seq.sv
module iq_word_seq
  import iq_fmt_pkg::*;
#(
  parameter int N_CH  = 6,
  parameter int SMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [N_CH-1:0]   en_i,
  input  logic              fmt_par_i,
  input  logic              rssi_all_i,
  input  logic [N_CH-1:0]   pend_i,
  input  logic [SMP_W-1:0]  pi_i [N_CH],
  input  logic [SMP_W-1:0]  pq_i [N_CH],
  input  logic [N_CH-1:0]   rpend_i,
  input  logic [SMP_W-1:0]  rval_i [N_CH],
  output logic [N_CH-1:0]   take_o,
  output logic [SMP_W-1:0]  data_o,
  output logic [1:0]        tag_o,
  output logic              vld_o
);
  localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int HALF  = SMP_W / 2;

  ph_e              ph_q;
  tag_e             tag_q;
  logic [SMP_W-1:0] qbuf_q, rbuf_q;
  logic             need_q;
  logic [N_CH-1:0]  avail;
  logic [SEL_W-1:0] sel;
  logic             any, grant;
  logic             need_d;

  assign avail = pend_i & en_i;

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (avail[c]) begin
        sel = SEL_W'(c);
        any = 1'b1;
      end
    end
  end

  assign grant  = tick_i && (ph_q == PH_IDLE) && any;
  assign need_d = rssi_all_i | rpend_i[sel];

  always_comb begin
    for (int c = 0; c < N_CH; c++) take_o[c] = grant && (sel == SEL_W'(c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      tag_q  <= TAG_I;
      data_o <= '0;
      vld_o  <= 1'b0;
      qbuf_q <= '0;
      rbuf_q <= '0;
      need_q <= 1'b0;
    end else if (tick_i) begin
      unique case (ph_q)
        PH_IDLE: begin
          if (any) begin
            vld_o  <= 1'b1;
            need_q <= need_d;
            qbuf_q <= pq_i[sel];
            rbuf_q <= rval_i[sel];
            if (fmt_par_i) begin
              data_o <= {pi_i[sel][SMP_W-1 -: HALF], pq_i[sel][SMP_W-1 -: HALF]};
              tag_q  <= TAG_IQ;
              ph_q   <= need_d ? PH_RSSI : PH_IDLE;
            end else begin
              data_o <= pi_i[sel];
              tag_q  <= TAG_I;
              ph_q   <= PH_Q;
            end
          end else begin
            vld_o <= 1'b0;
          end
        end
        PH_Q: begin
          data_o <= qbuf_q;
          tag_q  <= TAG_Q;
          vld_o  <= 1'b1;
          ph_q   <= need_q ? PH_RSSI : PH_IDLE;
        end
        PH_RSSI: begin
          data_o <= rbuf_q;
          tag_q  <= TAG_RSSI;
          vld_o  <= 1'b1;
          ph_q   <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign tag_o = tag_q;

  assert_hold_between_ticks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(data_o) && $stable(vld_o) && $stable(tag_o)));

  // an I word is always followed by its Q word
  assert_i_then_q_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && tag_q == TAG_I) |-> (ph_q == PH_Q));
endmodule

// File: rtl/iq_port_formatter.sv
module iq_port_formatter #(
  parameter int N_CH  = 6,
  parameter int SMP_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH-1:0]       cfg_ch_en_i,
  input  logic                  cfg_par_fmt_i,
  input  logic                  cfg_rssi_all_i,
  input  logic                  cfg_master_i,
  input  logic [1:0]            cfg_div_i,
  input  logic                  ext_pclk_i,
  input  logic [N_CH-1:0]       smp_vld_i,
  input  logic [N_CH*SMP_W-1:0] smp_i_i,
  input  logic [N_CH*SMP_W-1:0] smp_q_i,
  input  logic [N_CH-1:0]       rssi_upd_i,
  input  logic [N_CH*SMP_W-1:0] rssi_i,
  output logic                  pclk_oe_o,
  output logic                  port_ce_o,
  output logic [SMP_W-1:0]      out_data_o,
  output logic [1:0]            out_tag_o,
  output logic                  out_vld_o,
  output logic [N_CH-1:0]       ovf_o
);
  logic [N_CH-1:0]  en_q;
  logic             fmt_q, all_q, master_q;
  logic [1:0]       div_q;
  logic             tick;
  logic [N_CH-1:0]  take, pend, rpend;
  logic [SMP_W-1:0] pi [N_CH];
  logic [SMP_W-1:0] pq [N_CH];
  logic [SMP_W-1:0] rval [N_CH];

  // reset leaves the port clock pin undriven
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      fmt_q    <= 1'b0;
      all_q    <= 1'b0;
      master_q <= 1'b0;
      div_q    <= '0;
    end else begin
      en_q     <= cfg_ch_en_i;
      fmt_q    <= cfg_par_fmt_i;
      all_q    <= cfg_rssi_all_i;
      master_q <= cfg_master_i;
      div_q    <= cfg_div_i;
    end
  end

  assign pclk_oe_o = master_q;
  assign port_ce_o = tick;

  iq_port_tick #(.CNT_W(3)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .master_i   (master_q),
    .div_i      (div_q),
    .ext_pclk_i (ext_pclk_i),
    .tick_o     (tick)
  );

  iq_chan_store #(.N_CH(N_CH), .SMP_W(SMP_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .smp_vld_i  (smp_vld_i),
    .smp_i_i    (smp_i_i),
    .smp_q_i    (smp_q_i),
    .rssi_upd_i (rssi_upd_i),
    .rssi_i     (rssi_i),
    .take_i     (take),
    .pend_o     (pend),
    .pi_o       (pi),
    .pq_o       (pq),
    .rpend_o    (rpend),
    .rval_o     (rval),
    .ovf_o      (ovf_o)
  );

  iq_word_seq #(.N_CH(N_CH), .SMP_W(SMP_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .en_i       (en_q),
    .fmt_par_i  (fmt_q),
    .rssi_all_i (all_q),
    .pend_i     (pend),
    .pi_i       (pi),
    .pq_i       (pq),
    .rpend_i    (rpend),
    .rval_i     (rval),
    .take_o     (take),
    .data_o     (out_data_o),
    .tag_o      (out_tag_o),
    .vld_o      (out_vld_o)
  );

  // a granted channel must have been enabled and pending
  assert_grant_enabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|take) |-> ((take & en_q & pend) == take));
endmodule

// File: tb/tb_iq_port_formatter.sv
`timescale 1ns/1ps
module tb_iq_port_formatter;
  localparam int N = 6;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   en = '0;
  logic           par = 1'b0, all = 1'b0, master = 1'b0;
  logic [1:0]     div = '0;
  logic           ext = 1'b0;
  logic [N-1:0]   svld = '0, rupd = '0;
  logic [N*W-1:0] si = '0, sq = '0, rv = '0;
  logic           oe, ce, vld;
  logic [W-1:0]   dout;
  logic [1:0]     tag;
  logic [N-1:0]   ovf;

  int    n_vec = 0, n_err = 0;
  string cur_req = "R9";
  bit    ext_run = 1'b0;
  int    ext_cnt = 0;
  int    seq = 1;

  always #5 clk = ~clk;

  iq_port_formatter dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_ch_en_i(en), .cfg_par_fmt_i(par),
    .cfg_rssi_all_i(all), .cfg_master_i(master), .cfg_div_i(div),
    .ext_pclk_i(ext), .smp_vld_i(svld), .smp_i_i(si), .smp_q_i(sq),
    .rssi_upd_i(rupd), .rssi_i(rv), .pclk_oe_o(oe), .port_ce_o(ce),
    .out_data_o(dout), .out_tag_o(tag), .out_vld_o(vld), .ovf_o(ovf)
  );

  // ---------------- behavioural model ----------------
  int         m_cnt, m_div, m_ph;
  bit         m_e1, m_e2, m_master, m_fmt, m_all, m_need, m_vld;
  bit [N-1:0] m_en, m_pend, m_rp, m_ovf;
  bit [W-1:0] m_pi [N];
  bit [W-1:0] m_pq [N];
  bit [W-1:0] m_rv [N];
  bit [W-1:0] m_qb, m_rb, m_data;
  bit [1:0]   m_tag;

  function automatic bit m_tick();
    return m_master ? (m_cnt == (1 << m_div) - 1) : (m_e1 && !m_e2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_ph = 0; m_e1 = 0; m_e2 = 0; m_master = 0;
      m_fmt = 0; m_all = 0; m_need = 0; m_vld = 0; m_en = '0; m_pend = '0;
      m_rp = '0; m_ovf = '0; m_qb = '0; m_rb = '0; m_data = '0; m_tag = 2'b00;
      for (int c = 0; c < N; c++) begin m_pi[c] = '0; m_pq[c] = '0; m_rv[c] = '0; end
    end else begin
      bit t;
      t = m_tick();
      if (m_master) m_cnt = t ? 0 : (m_cnt + 1) % 8; else m_cnt = 0;
      m_e2 = m_e1; m_e1 = ext;
      if (t) begin
        if (m_ph == 0) begin
          int s;
          s = -1;
          for (int c = N - 1; c >= 0; c--) if (m_en[c] && m_pend[c]) s = c;
          if (s >= 0) begin
            m_vld = 1; m_need = m_all || m_rp[s]; m_qb = m_pq[s]; m_rb = m_rv[s];
            if (m_fmt) begin
              m_data = {m_pi[s][15:8], m_pq[s][15:8]}; m_tag = 2'b10;
              m_ph = m_need ? 2 : 0;
            end else begin
              m_data = m_pi[s]; m_tag = 2'b00; m_ph = 1;
            end
            m_pend[s] = 0; m_rp[s] = 0;
          end else m_vld = 0;
        end else if (m_ph == 1) begin
          m_data = m_qb; m_tag = 2'b01; m_vld = 1; m_ph = m_need ? 2 : 0;
        end else begin
          m_data = m_rb; m_tag = 2'b11; m_vld = 1; m_ph = 0;
        end
      end
      for (int c = 0; c < N; c++) begin
        if (m_en[c] && svld[c]) begin
          if (m_pend[c]) m_ovf[c] = 1;
          m_pend[c] = 1; m_pi[c] = si[c*W +: W]; m_pq[c] = sq[c*W +: W];
        end
        if (rupd[c]) begin m_rp[c] = 1; m_rv[c] = rv[c*W +: W]; end
      end
      m_en = en; m_fmt = par; m_all = all; m_master = master; m_div = int'(div);
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // compare every clock, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("port_ce (R7 R8)", 32'(ce), 32'(m_tick()));
      chk("pclk_oe (R7 R8)", 32'(oe), 32'(m_master));
      chk("valid (R10)", 32'(vld), 32'(m_vld));
      if (m_vld) begin
        chk("tag (R3 R4 R5 R6)", 32'(tag), 32'(m_tag));
        chk("data (R2 R3 R4)", 32'(dout), 32'(m_data));
      end
      chk("overflow (R11)", 32'(ovf), 32'(m_ovf));
    end
  end

  always @(negedge clk) begin
    if (ext_run) begin
      ext_cnt++;
      if (ext_cnt >= 3) begin ext_cnt = 0; ext = ~ext; end
    end
  end

  task automatic push(logic [N-1:0] mask, logic [N-1:0] upd);
    @(negedge clk);
    svld = mask; rupd = upd;
    for (int c = 0; c < N; c++) begin
      si[c*W +: W] = {4'(c), 12'(seq)};
      sq[c*W +: W] = ~{4'(c), 12'(seq)} ^ 16'h0f0f;
      rv[c*W +: W] = {8'ha0 + 8'(c), 8'(seq)};
      seq++;
    end
    @(negedge clk);
    svld = '0; rupd = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(10 * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    // R9: reset state
    idle(3);
    cur_req = "R9";
    chk("reset pclk_oe", 32'(oe), 32'd0);
    chk("reset valid", 32'(vld), 32'd0);
    chk("reset overflow", 32'(ovf), 32'd0);
    rst_n = 1'b1;
    idle(2);
    chk("slave after reset", 32'(oe), 32'd0);

    // slave clock, divisor field set but ignored; separate words; RSSI on update
    cur_req = "R1 R2 R4 R6 R8";
    en = 6'b101101; div = 2'b11; par = 0; all = 0; master = 0; ext_run = 1;
    idle(2);
    push(6'b111111, 6'b001001);
    idle(140);
    push(6'b111111, 6'b000000);
    idle(140);
    push(6'b100001, 6'b100000);
    idle(80);

    // master clock, combined words, RSSI always, all divisors
    cur_req = "R3 R5 R7 R10";
    ext_run = 0; master = 1; div = 2'b00; par = 1; all = 1; en = 6'b111111;
    idle(2);
    push(6'b111111, 6'b000010);
    idle(30);
    div = 2'b01; push(6'b010101, 6'b000000); idle(40);
    div = 2'b10; push(6'b111111, 6'b000000); idle(80);
    div = 2'b11; push(6'b110011, 6'b000000); idle(160);

    // overflow: back-to-back samples on one channel
    cur_req = "R11";
    par = 0; all = 0;
    push(6'b000100, 6'b000000);
    push(6'b000100, 6'b000000);
    push(6'b000100, 6'b000000);
    idle(100);
    chk("channel 2 overflow flag", 32'(ovf[2]), 32'd1);

    // all channels disabled: samples dropped
    cur_req = "R1 R7";
    en = '0;
    push(6'b111111, 6'b111111);
    idle(80);
    chk("no word from disabled channels", 32'(vld), 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule